// File: doc/BRIEF.md
# Access Violation Capture and Sync Unit

This unit collects bus access-permission violations that an external checker flags. It presents them to software through a small register map. Each violation event carries an index, a slave-group number, the offending master and domain identifiers, the direction of the access and a 36-bit address. When reporting is on, the event does two things. It raises the status bit for its index. It also stores a full record for its group, unless that group already holds one.

The record details cannot be read directly. Software first writes a one-hot group choice to the select register. It then writes 1 to the sync-control register and polls until that register reads 3. After that, the two debug registers hold the record. Software reads them, writes 0 to sync control, and clears the group's pending bit.

Status and mask bits are packed 32 to a word. A level interrupt is raised while reporting is on and any status bit whose mask bit is clear is set.

Top module: `viol_capture_unit`

## Requirements
- R1: After reset every register reads 0, the interrupt is low and sync control reads 0.
- R2: Writing the control register at 0xF00 with bit 31 set turns reporting on. Otherwise, a write with bit 2 set turns it off. Control reads back the reporting state in bit 31 and 0 in all other bits.
- R3: While reporting is on, an event with index m sets bit m%32 of the status word at 0x400+4*(m/32). Events arriving while reporting is off, and events with an index at or above NUM_IDX, leave every status word unchanged.
- R4: Writing 1 to a status bit clears it. If an event sets the same bit in the same cycle, the bit stays set. Status and mask bits at or above NUM_IDX read 0.
- R5: The mask word at 0x000+4*w is read/write over its implemented bits. The interrupt is high exactly when reporting is on and some status bit is set whose mask bit is clear.
- R6: Sync status at 0xF10 holds one pending bit per group, with bit g for group g. A captured event sets the bit. Writing 1 to the bit clears it.
- R7: While a group's pending bit is set, further events for that group are dropped and the stored record is kept.
- R8: Sync select at 0xF14 is read/write over NUM_GRP bits. Writing 1 to sync control at 0xF20 while it reads 0, with a one-hot select, makes the register read 1 for SYNC_CYC cycles and then read 3. The value 3 holds until 0 is written, which returns the register to 0.
- R9: A start written while the select value is zero or has more than one bit set leaves sync control reading 1 indefinitely. In that case the debug registers do not change.
- R10: After a sync completes, debug 0 at 0x900 holds the master ID in [15:0], the domain ID in [21:16], the write flag in bit 22, the read flag in bit 23 (the inverse of the write flag), address bits 35:32 in [27:24], and 0 in [31:28]. Debug 1 at 0x904 holds address bits 31:0.
- R11: The debug registers change only in the cycle a sync completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address, used for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_valid | input | 1 | Violation event present this cycle |
| ev_index | input | $clog2(NUM_IDX+1) | Violation index |
| ev_group | input | $clog2(NUM_GRP) | Slave group of the event |
| ev_master | input | 16 | Master ID of the offending access |
| ev_domain | input | 6 | Domain ID of the offending access |
| ev_write | input | 1 | 1 for a write access, 0 for a read access |
| ev_addr | input | 36 | Address of the offending access |
| irq | output | 1 | Level interrupt |

## Verification
The bench places indices in the partial last status word, where a design that implemented the full 32 bits would read back mask bits that do not exist. It also uses an index just past the count, which a design without a range check would record. It drives a second event into a group that is already pending, which catches a design that overwrites the first record. It issues a start with a two-hot select, which catches a design that completes anyway and loads a blended record into the debug registers. It lands an event and a write-1-to-clear on the same status bit in the same cycle, which catches a design that lets the clear win and loses the violation. The sync-control readback is checked on the exact cycle it turns to 3, which exposes an off-by-one in the sync delay.

// File: rtl/viol_capture_unit.sv
module viol_capture_unit #(
  parameter int NUM_IDX  = 519,
  parameter int NUM_GRP  = 4,
  parameter int SYNC_CYC = 8,
  localparam int IW = $clog2(NUM_IDX + 1),
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [11:0]   bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ev_valid,
  input  logic [IW-1:0] ev_index,
  input  logic [GW-1:0] ev_group,
  input  logic [15:0]   ev_master,
  input  logic [5:0]    ev_domain,
  input  logic          ev_write,
  input  logic [35:0]   ev_addr,
  output logic          irq
);
  localparam int NW = (NUM_IDX + 31) / 32;
  localparam int CW = (SYNC_CYC > 1) ? $clog2(SYNC_CYC) : 1;
  localparam logic [11:0] A_CTRL  = 12'hF00;
  localparam logic [11:0] A_SHSTA = 12'hF10;
  localparam logic [11:0] A_SHSEL = 12'hF14;
  localparam logic [11:0] A_SHCON = 12'hF20;
  localparam logic [11:0] A_DBG0  = 12'h900;
  localparam logic [11:0] A_DBG1  = 12'h904;

  logic              rep_en;
  logic [NW*32-1:0]  sta, msk;
  logic [NW-1:0]     wr_msk, wr_sta;
  logic [NUM_GRP-1:0] pend, sel, cap;
  logic [1:0]        sh_con;
  logic              sh_run;
  logic [CW-1:0]     cnt;
  logic [31:0]       dbg0, dbg1;
  logic [59:0]       rec [NUM_GRP];
  logic [59:0]       sel_rec, new_rec;
  logic              ev_ok, sel_ok, wr_con;

  assign ev_ok   = rep_en && ev_valid;
  assign new_rec = {ev_addr[35:32], ~ev_write, ev_write, ev_domain, ev_master, ev_addr[31:0]};
  assign sel_ok  = (sel != '0) && ((sel & (sel - NUM_GRP'(1))) == '0);
  assign wr_con  = bus_wr && bus_addr == A_SHCON;
  assign irq     = rep_en && |(sta & ~msk);

  for (genvar w = 0; w < NW; w++) begin : g_dec
    assign wr_msk[w] = bus_wr && bus_addr[11:10] == 2'b00 && bus_addr[9:2] == 8'(w);
    assign wr_sta[w] = bus_wr && bus_addr[11:10] == 2'b01 && bus_addr[9:2] == 8'(w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta <= '0;
      msk <= '0;
    end else begin
      for (int i = 0; i < NW*32; i++) begin
        if (i < NUM_IDX) begin
          if (wr_msk[i/32]) msk[i] <= bus_wdata[i%32];
          if (ev_ok && ev_index == IW'(i)) sta[i] <= 1'b1;
          else if (wr_sta[i/32] && bus_wdata[i%32]) sta[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_en <= 1'b0;
    else if (bus_wr && bus_addr == A_CTRL) begin
      if (bus_wdata[31]) rep_en <= 1'b1;
      else if (bus_wdata[2]) rep_en <= 1'b0;
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++)
      cap[g] = ev_ok && ev_group == GW'(g) && !pend[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      for (int g = 0; g < NUM_GRP; g++) rec[g] <= '0;
    end else begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (cap[g]) begin
          pend[g] <= 1'b1;
          rec[g]  <= new_rec;
        end else if (bus_wr && bus_addr == A_SHSTA && bus_wdata[g]) begin
          pend[g] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    sel_rec = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (sel[g]) sel_rec = sel_rec | rec[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel    <= '0;
      sh_con <= 2'b00;
      sh_run <= 1'b0;
      cnt    <= '0;
      dbg0   <= '0;
      dbg1   <= '0;
    end else begin
      if (bus_wr && bus_addr == A_SHSEL) sel <= bus_wdata[NUM_GRP-1:0];
      if (wr_con && bus_wdata == 32'h0) begin
        sh_con <= 2'b00;
        sh_run <= 1'b0;
      end else if (wr_con && bus_wdata == 32'h1 && sh_con == 2'b00) begin
        sh_con <= 2'b01;
        sh_run <= sel_ok;
        cnt    <= CW'(SYNC_CYC - 1);
      end else if (sh_run) begin
        if (cnt == '0) begin
          sh_con <= 2'b11;
          sh_run <= 1'b0;
          dbg0   <= {4'b0, sel_rec[59:32]};
          dbg1   <= sel_rec[31:0];
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {rep_en, 31'b0};
      A_SHSTA: bus_rdata[NUM_GRP-1:0] = pend;
      A_SHSEL: bus_rdata[NUM_GRP-1:0] = sel;
      A_SHCON: bus_rdata[1:0] = sh_con;
      A_DBG0:  bus_rdata = dbg0;
      A_DBG1:  bus_rdata = dbg1;
      default: begin
        for (int w = 0; w < NW; w++) begin
          if (bus_addr[9:2] == 8'(w)) begin
            if (bus_addr[11:10] == 2'b00) bus_rdata = msk[w*32 +: 32];
            else if (bus_addr[11:10] == 2'b01) bus_rdata = sta[w*32 +: 32];
          end
        end
      end
    endcase
  end
endmodule

module viol_capture_unit_chk #(
  parameter int NUM_GRP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               en,
  input logic [1:0]         sh_con,
  input logic               sh_run,
  input logic [NUM_GRP-1:0] pend,
  input logic               bus_wr,
  input logic [11:0]        bus_addr,
  input logic               ev_valid,
  input logic [31:0]        dbg0,
  input logic [31:0]        dbg1
);
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);
  assert_con_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sh_con != 2'b10);
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_con == 2'b11) |-> $past(sh_con) == 2'b01);
  assert_bad_start_stuck_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_con == 2'b01 && !sh_run) |=> sh_con != 2'b11);
  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !(bus_wr && bus_addr == 12'hF10)) |=> $stable(pend));
  assert_dbg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_run |=> ($stable(dbg0) && $stable(dbg1)));
endmodule

bind viol_capture_unit viol_capture_unit_chk #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .en(rep_en), .sh_con(sh_con),
  .sh_run(sh_run), .pend(pend), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ev_valid(ev_valid), .dbg0(dbg0), .dbg1(dbg1)
);

// File: tb/sim_viol_capture_unit.sv
module sim_viol_capture_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IDX = 519;
  localparam int NUM_GRP = 4;
  localparam int SYNC_CYC = 8;
  localparam int IW = $clog2(NUM_IDX + 1);
  localparam int GW = $clog2(NUM_GRP);

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ev_valid = 0;
  logic [IW-1:0] ev_index = 0;
  logic [GW-1:0] ev_group = 0;
  logic [15:0] ev_master = 0;
  logic [5:0] ev_domain = 0;
  logic ev_write = 0;
  logic [35:0] ev_addr = 0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  viol_capture_unit #(.NUM_IDX(NUM_IDX), .NUM_GRP(NUM_GRP), .SYNC_CYC(SYNC_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_valid(ev_valid),
    .ev_index(ev_index), .ev_group(ev_group), .ev_master(ev_master),
    .ev_domain(ev_domain), .ev_write(ev_write), .ev_addr(ev_addr), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic ev(input int idx, input int grp, input logic [15:0] m,
                    input logic [5:0] d, input logic w, input logic [35:0] ad);
    @(negedge clk);
    ev_valid = 1; ev_index = IW'(idx); ev_group = GW'(grp);
    ev_master = m; ev_domain = d; ev_write = w; ev_addr = ad;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic t_reset;
    rd_check("R1 ctrl", 12'hF00, 0);
    rd_check("R1 shsta", 12'hF10, 0);
    rd_check("R1 shcon", 12'hF20, 0);
    rd_check("R1 dbg0", 12'h900, 0);
    rd_check("R1 status0", 12'h400, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl;
    wr(12'hF00, 32'h8000_0000);
    rd_check("R2 enable", 12'hF00, 32'h8000_0000);
    wr(12'hF00, 32'h0000_0004);
    rd_check("R2 disable", 12'hF00, 0);
    ev(3, 1, 16'h1, 6'h1, 1, 36'h0);
    rd_check("R3 off ignored", 12'h400, 0);
    rd_check("R6 off no pend", 12'hF10, 0);
    wr(12'hF00, 32'h8000_0004);
    rd_check("R2 bit31 wins", 12'hF00, 32'h8000_0000);
  endtask

  task automatic t_status;
    ev(37, 3, 16'h0, 6'h0, 0, 36'h0);
    rd_check("R3 idx37", 12'h404, 32'h0000_0020);
    check("R5 irq raised", {31'b0, irq}, 1);
    wr(12'h404, 32'h0000_0020);
    rd_check("R4 w1c", 12'h404, 0);
    check("R5 irq cleared", {31'b0, irq}, 0);
    ev(518, 3, 16'h0, 6'h0, 0, 36'h0);
    rd_check("R3 idx518", 12'h440, 32'h0000_0040);
    ev(519, 3, 16'h0, 6'h0, 0, 36'h0);
    rd_check("R3 idx out of range", 12'h440, 32'h0000_0040);
    wr(12'h040, 32'hFFFF_FFFF);
    rd_check("R4 mask partial word", 12'h040, 32'h0000_007F);
    check("R5 masked irq", {31'b0, irq}, 0);
    wr(12'h040, 32'h0);
    check("R5 unmasked irq", {31'b0, irq}, 1);
    wr(12'h440, 32'hFFFF_FFFF);
    rd_check("R4 w1c last word", 12'h440, 0);
    ev(1, 3, 16'h0, 6'h0, 0, 36'h0);
    @(negedge clk);
    bus_wr = 1; bus_addr = 12'h400; bus_wdata = 32'h2;
    ev_valid = 1; ev_index = IW'(1);
    @(negedge clk);
    bus_wr = 0; ev_valid = 0;
    rd_check("R4 set beats clear", 12'h400, 32'h2);
    wr(12'h400, 32'h2);
    rd_check("R4 cleared after", 12'h400, 0);
  endtask

  task automatic t_sync;
    wr(12'hF10, 32'hF);
    ev(10, 2, 16'h1234, 6'h15, 1, 36'hA_DEAD_BEEF);
    rd_check("R6 pending set", 12'hF10, 32'h4);
    ev(11, 2, 16'h9999, 6'h01, 0, 36'h1_1111_1111);
    wr(12'hF14, 32'h4);
    rd_check("R8 select readback", 12'hF14, 32'h4);
    wr(12'hF20, 32'h1);
    repeat (SYNC_CYC - 1) @(negedge clk);
    rd_check("R8 still busy", 12'hF20, 32'h1);
    @(negedge clk);
    rd_check("R8 done", 12'hF20, 32'h3);
    rd_check("R10 dbg0 write", 12'h900, 32'h0A55_1234);
    rd_check("R7 first record kept", 12'h904, 32'hDEAD_BEEF);
    wr(12'hF20, 32'h0);
    rd_check("R8 stop", 12'hF20, 0);
    wr(12'hF10, 32'h4);
    rd_check("R6 w1c", 12'hF10, 0);
    ev(12, 0, 16'hBEEF, 6'h3F, 0, 36'h5_0000_1000);
    wr(12'hF14, 32'h1);
    wr(12'hF20, 32'h1);
    repeat (SYNC_CYC) @(negedge clk);
    rd_check("R10 dbg0 read", 12'h900, 32'h05BF_BEEF);
    rd_check("R10 dbg1", 12'h904, 32'h0000_1000);
    wr(12'hF20, 32'h0);
  endtask

  task automatic t_bad_sel;
    ev(13, 1, 16'h7777, 6'h07, 1, 36'hF_FFFF_FFFF);
    wr(12'hF14, 32'h3);
    wr(12'hF20, 32'h1);
    repeat (3 * SYNC_CYC) @(negedge clk);
    rd_check("R9 stuck busy", 12'hF20, 32'h1);
    rd_check("R9 R11 dbg0 held", 12'h900, 32'h05BF_BEEF);
    rd_check("R11 dbg1 held", 12'h904, 32'h0000_1000);
    wr(12'hF20, 32'h0);
    wr(12'hF14, 32'h0);
    wr(12'hF20, 32'h1);
    repeat (2 * SYNC_CYC) @(negedge clk);
    rd_check("R9 zero select", 12'hF20, 32'h1);
    wr(12'hF20, 32'h0);
    rd_check("R8 back to idle", 12'hF20, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_status();
    t_sync();
    t_bad_sel();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule